// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Bracketing

This block keeps a 4096-row dynamic memory refreshed on behalf of an access controller that otherwise owns the row strobe, the column strobe and the write strobe. After reset it waits out the power-up pause and then runs a burst of column-before-row refresh cycles. Only after that burst does it raise `ready`. From then on an interval timer adds one owed refresh per period, which is about 15.6 µs by default at 250 MHz, so all rows are covered within 64 ms. The scheduler asks for the strobe pins with `busReq`, waits for `busGrant`, and then drives the strobes itself.

Refreshes that come due while the access controller holds the pins are counted, up to a parameterized cap. Once the grant arrives they are issued back to back under a single grant. In every refresh cycle the column strobe falls before the row strobe, and the write strobe stays high so that the cycle cannot be taken as a test-mode entry.

A host can ask for low-power self-refresh by holding `selfReq` high. The request is taken only when nothing is owed. The block then runs one ordinary refresh and opens a column-before-row cycle whose row-strobe low time is at least the self-refresh minimum, which lies above 100 µs; that keeps the hold time out of the forbidden 10 to 100 µs window. The cycle lasts until the host drops `selfReq`. On exit the block holds a longer precharge and runs one more ordinary refresh before it releases the pins. The interval timer is stopped while this sequence runs and starts again from zero when it ends.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and right after it, `rasN`, `casN` and `weN` are 1 and `busReq` and `ready` are 0. The first row-strobe fall comes no earlier than INIT_WAIT_CYC cycles after reset. `ready` rises only after exactly INIT_REFRESHES refresh cycles, and `inSelf` is never 1 while `ready` is 0.
- R2: Once `ready` is 1 and `busGrant` stays 1, consecutive row-strobe falls are exactly INTERVAL_CYC cycles apart.
- R3: `rasN` and `casN` stay 1 whenever `busGrant` is 0, even while `busReq` is 1.
- R4: In each refresh cycle `casN` is 0 for at least CSR_CYC cycles before `rasN` falls, and it stays 0 for as long as `rasN` is 0.
- R5: `weN` is 1 at every row-strobe fall.
- R6: The count of owed refreshes stops at MAX_OWED. Owed refreshes are issued under one grant, with row-strobe falls CSR_CYC+RAS_LOW_CYC+PRE_CYC cycles apart.
- R7: A self-refresh request is taken only when no refresh is owed. Owed refreshes are issued first, and `inSelf` stays 0 during them.
- R8: The cycle that enters self-refresh starts exactly CSR_CYC+RAS_LOW_CYC+PRE_CYC cycles after the fall of one extra ordinary refresh.
- R9: During self-refresh `inSelf` is 1 and `rasN` is 0. The row-strobe low time is SELF_MIN_CYC cycles when `selfReq` drops early. Otherwise it lasts until `selfReq` is seen low.
- R10: After self-refresh, `rasN` stays 1 for exactly RPS_CYC+CSR_CYC cycles. One ordinary refresh follows, and then `busReq` drops.
- R11: No refresh is owed for time spent in self-refresh. After a self-refresh that lasts several intervals, no further refresh follows the exit refresh within the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Access controller hands over the strobe pins |
| selfReq | input | 1 | Host level request to stay in self-refresh |
| busReq | output | 1 | Scheduler asks for the strobe pins |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write strobe, held high |
| ready | output | 1 | Power-up sequence has finished |
| inSelf | output | 1 | Memory is held in self-refresh |

## Verification
A miscounted owed-refresh register shows up at the ports within one burst. The number of row-strobe falls between the grant and the drop of `busReq` then differs from the saturated count, or the power-up burst ends early or late and moves the rise of `ready`. A wrong phase timer or sequencer state changes the gap between row-strobe falls, the self-refresh low time or the exit precharge by whole cycles, and the next refresh edge exposes it. A timer that keeps running through self-refresh shows up as an extra refresh inside the first interval after exit.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // Which duration the phase timer loads
  typedef enum logic [2:0] {
    T_CSR,
    T_RAS,
    T_PRE,
    T_SELF,
    T_RPS
  } timeSel_e;

  // Strobes from the sequencer to the counters
  typedef struct packed {
    logic     load;      // load the phase timer
    timeSel_e sel;       // duration to load
    logic     consume;   // one owed refresh has been issued
    logic     seed;      // start the power-up burst
    logic     holdTick;  // interval timer held at zero
  } refCtl_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import dram_refresh_pkg::*;
#(
  parameter int INIT_WAIT_CYC  = 50000,
  parameter int INIT_REFRESHES = 8,
  parameter int INTERVAL_CYC   = 3900,
  parameter int MAX_OWED       = 8,
  parameter int CSR_CYC        = 2,
  parameter int RAS_LOW_CYC    = 15,
  parameter int PRE_CYC        = 10,
  parameter int SELF_MIN_CYC   = 25001,
  parameter int RPS_CYC        = 28
) (
  input  logic    clk,
  input  logic    rstN,
  input  refCtl_t ctl,
  output logic    timerDone,
  output logic    owedZero,
  output logic    owedMulti
);

  localparam int LONG_A    = (INIT_WAIT_CYC > SELF_MIN_CYC) ? INIT_WAIT_CYC : SELF_MIN_CYC;
  localparam int SHORT_A   = (RAS_LOW_CYC > PRE_CYC) ? RAS_LOW_CYC : PRE_CYC;
  localparam int SHORT_B   = (RPS_CYC > CSR_CYC) ? RPS_CYC : CSR_CYC;
  localparam int SHORT_MAX = (SHORT_A > SHORT_B) ? SHORT_A : SHORT_B;
  localparam int PHASE_MAX = (LONG_A > SHORT_MAX) ? LONG_A : SHORT_MAX;
  localparam int PHASE_W   = $clog2(PHASE_MAX) + 1;
  localparam int IV_W      = $clog2(INTERVAL_CYC) + 1;
  localparam int OWED_W    = $clog2(MAX_OWED + 1);

  logic [PHASE_W-1:0] phaseCnt, loadVal;
  logic [IV_W-1:0]    ivCnt;
  logic [OWED_W-1:0]  owedCnt;
  logic               tick, addOne;

  // Phase timer: a load of N-1 makes a phase last N cycles
  always_comb begin
    unique case (ctl.sel)
      T_CSR:   loadVal = PHASE_W'(CSR_CYC - 1);
      T_RAS:   loadVal = PHASE_W'(RAS_LOW_CYC - 1);
      T_PRE:   loadVal = PHASE_W'(PRE_CYC - 1);
      T_SELF:  loadVal = PHASE_W'(SELF_MIN_CYC - 1);
      T_RPS:   loadVal = PHASE_W'(RPS_CYC - 1);
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= PHASE_W'(INIT_WAIT_CYC - 1);
    else if (ctl.load)        phaseCnt <= loadVal;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - PHASE_W'(1);
  end

  assign timerDone = (phaseCnt == '0);

  // Interval timer
  assign tick = !ctl.holdTick && (ivCnt == IV_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN || ctl.holdTick || tick) ivCnt <= '0;
    else                               ivCnt <= ivCnt + IV_W'(1);
  end

  // Owed-refresh counter, capped at MAX_OWED
  assign addOne = tick && ((owedCnt != OWED_W'(MAX_OWED)) || ctl.consume);

  always_ff @(posedge clk) begin
    if (!rstN)         owedCnt <= '0;
    else if (ctl.seed) owedCnt <= OWED_W'(INIT_REFRESHES);
    else begin
      unique case ({addOne, ctl.consume})
        2'b10:   owedCnt <= owedCnt + OWED_W'(1);
        2'b01:   owedCnt <= owedCnt - OWED_W'(1);
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  assign owedZero  = (owedCnt == '0);
  assign owedMulti = (owedCnt > OWED_W'(1));

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import dram_refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busGrant,
  input  logic    selfReq,
  input  logic    timerDone,
  input  logic    owedZero,
  input  logic    owedMulti,
  output refCtl_t ctl,
  output logic    busReq,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output logic    ready,
  output logic    inSelf
);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_REQ, S_CAS, S_RAS, S_PRE, S_RPS} state_e;
  // Role of the current refresh cycle
  typedef enum logic [1:0] {G_NORM, G_PRE, G_SELF, G_POST} stage_e;

  state_e state, stateNx;
  stage_e stage, stageNx;
  logic   readyR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_INIT;
      stage  <= G_NORM;
      readyR <= 1'b0;
    end else begin
      state  <= stateNx;
      stage  <= stageNx;
      readyR <= readyR || (state == S_IDLE && owedZero);
    end
  end

  always_comb begin
    stateNx      = state;
    stageNx      = stage;
    ctl          = '0;
    ctl.sel      = T_CSR;
    ctl.holdTick = !readyR || (stage != G_NORM);
    unique case (state)
      S_INIT: if (timerDone) begin
        ctl.seed = 1'b1;
        stateNx  = S_IDLE;
      end
      S_IDLE: begin
        if (!owedZero) begin
          stateNx = S_REQ;
          stageNx = G_NORM;
        end else if (readyR && selfReq) begin
          stateNx = S_REQ;
          stageNx = G_PRE;
        end
      end
      S_REQ: if (busGrant) begin
        ctl.load = 1'b1;
        ctl.sel  = T_CSR;
        stateNx  = S_CAS;
      end
      S_CAS: if (timerDone) begin
        ctl.load = 1'b1;
        ctl.sel  = (stage == G_SELF) ? T_SELF : T_RAS;
        stateNx  = S_RAS;
      end
      S_RAS: if (timerDone && !(stage == G_SELF && selfReq)) begin
        ctl.load = 1'b1;
        ctl.sel  = (stage == G_SELF) ? T_RPS : T_PRE;
        stateNx  = (stage == G_SELF) ? S_RPS : S_PRE;
      end
      S_PRE: if (timerDone) begin
        unique case (stage)
          G_NORM: begin
            ctl.consume = 1'b1;
            if (owedMulti) begin
              ctl.load = 1'b1;
              stateNx  = S_CAS;
            end else begin
              stateNx = S_IDLE;
            end
          end
          G_PRE: begin
            stageNx  = G_SELF;
            ctl.load = 1'b1;
            stateNx  = S_CAS;
          end
          default: begin
            stageNx = G_NORM;
            stateNx = S_IDLE;
          end
        endcase
      end
      S_RPS: if (timerDone) begin
        stageNx  = G_POST;
        ctl.load = 1'b1;
        stateNx  = S_CAS;
      end
      default: stateNx = S_INIT;
    endcase
  end

  assign busReq = !(state == S_INIT || state == S_IDLE);
  assign rasN   = (state != S_RAS);
  assign casN   = !(state == S_CAS || state == S_RAS);
  assign weN    = 1'b1;
  assign ready  = readyR;
  assign inSelf = (state == S_RAS) && (stage == G_SELF);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int INIT_WAIT_CYC  = 50000,
  parameter int INIT_REFRESHES = 8,
  parameter int INTERVAL_CYC   = 3900,
  parameter int MAX_OWED       = 8,
  parameter int CSR_CYC        = 2,
  parameter int RAS_LOW_CYC    = 15,
  parameter int PRE_CYC        = 10,
  parameter int SELF_MIN_CYC   = 25001,
  parameter int RPS_CYC        = 28
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  input  logic selfReq,
  output logic busReq,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic ready,
  output logic inSelf
);

  refCtl_t ctl;
  logic    timerDone, owedZero, owedMulti;

  refresh_datapath #(
    .INIT_WAIT_CYC (INIT_WAIT_CYC),
    .INIT_REFRESHES(INIT_REFRESHES),
    .INTERVAL_CYC  (INTERVAL_CYC),
    .MAX_OWED      (MAX_OWED),
    .CSR_CYC       (CSR_CYC),
    .RAS_LOW_CYC   (RAS_LOW_CYC),
    .PRE_CYC       (PRE_CYC),
    .SELF_MIN_CYC  (SELF_MIN_CYC),
    .RPS_CYC       (RPS_CYC)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .timerDone(timerDone),
    .owedZero (owedZero),
    .owedMulti(owedMulti)
  );

  refresh_control uControl (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .selfReq  (selfReq),
    .timerDone(timerDone),
    .owedZero (owedZero),
    .owedMulti(owedMulti),
    .ctl      (ctl),
    .busReq   (busReq),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ready    (ready),
    .inSelf   (inSelf)
  );

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int CSR_CYC      = 2,
  parameter int SELF_MIN_CYC = 25001,
  parameter int RPS_CYC      = 28
) (
  input logic clk,
  input logic rstN,
  input logic busGrant,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic ready,
  input logic inSelf
);

  logic [31:0] casLowRun, rasLowRun, rasHighRun;
  logic        afterSelf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      casLowRun  <= '0;
      rasLowRun  <= '0;
      rasHighRun <= '0;
      afterSelf  <= 1'b0;
    end else begin
      casLowRun  <= casN ? '0 : casLowRun + 32'd1;
      rasLowRun  <= rasN ? '0 : rasLowRun + 32'd1;
      rasHighRun <= rasN ? rasHighRun + 32'd1 : '0;
      if (inSelf)     afterSelf <= 1'b1;
      else if (!rasN) afterSelf <= 1'b0;
    end
  end

  a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (casLowRun >= 32'(CSR_CYC)));

  a_r4_cas_held: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  a_r5_we_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> weN);

  a_r3_grant_owns: assert property (@(posedge clk) disable iff (!rstN)
    !busGrant |-> (rasN && casN));

  a_r1_self_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    inSelf |-> ready);

  a_r9_self_min: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasN) && $past(inSelf)) |-> (rasLowRun >= 32'(SELF_MIN_CYC)));

  a_r10_self_precharge: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && afterSelf) |-> (rasHighRun >= 32'(RPS_CYC)));

endmodule

bind dram_refresh_sched dram_refresh_chk #(
  .CSR_CYC     (CSR_CYC),
  .SELF_MIN_CYC(SELF_MIN_CYC),
  .RPS_CYC     (RPS_CYC)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busGrant(busGrant),
  .rasN    (rasN),
  .casN    (casN),
  .weN     (weN),
  .ready   (ready),
  .inSelf  (inSelf)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;

  localparam int INIT_WAIT  = 20;
  localparam int INIT_REF   = 8;
  localparam int INTERVAL   = 100;
  localparam int MAXOWED    = 8;
  localparam int CSR        = 2;
  localparam int RASLOW     = 4;
  localparam int PRE        = 3;
  localparam int SELFMIN    = 30;
  localparam int RPS        = 5;
  localparam int BURST_GAP  = CSR + RASLOW + PRE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b1;
  logic selfReq = 1'b0;
  logic busReq, rasN, casN, weN, ready, inSelf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .INIT_WAIT_CYC(INIT_WAIT), .INIT_REFRESHES(INIT_REF), .INTERVAL_CYC(INTERVAL),
    .MAX_OWED(MAXOWED), .CSR_CYC(CSR), .RAS_LOW_CYC(RASLOW), .PRE_CYC(PRE),
    .SELF_MIN_CYC(SELFMIN), .RPS_CYC(RPS)
  ) u0 (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .selfReq(selfReq),
    .busReq(busReq), .rasN(rasN), .casN(casN), .weN(weN),
    .ready(ready), .inSelf(inSelf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Strobe monitor, sampled at the falling clock edge
  int  cyc = 0, rstCyc = 0;
  int  fallCount = 0, lastFall = 0, prevFall = 0;
  int  lowRun = 0, highRun = 0, casRun = 0;
  int  lastLowLen = 0, lastHigh = 0;
  bit  lastFallSelf = 1'b0, prevRas = 1'b1, casBroke = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      rstCyc = cyc;
      prevRas = 1'b1;
    end else begin
      if (prevRas && !rasN) begin
        fallCount++;
        prevFall = lastFall;
        lastFall = cyc;
        lastHigh = highRun;
        lastFallSelf = inSelf;
        casBroke = 1'b0;
        chk(casRun >= CSR, "R4 column strobe lead", casRun, CSR);
        chk(weN === 1'b1, "R5 write strobe high at row fall", int'(weN), 1);
      end
      if (!rasN && casN) casBroke = 1'b1;
      if (!prevRas && rasN) begin
        lastLowLen = lowRun;
        chk(!casBroke, "R4 column strobe held through row low", int'(casBroke), 0);
      end
      lowRun  = rasN ? 0 : lowRun + 1;
      highRun = rasN ? highRun + 1 : 0;
      casRun  = casN ? 0 : casRun + 1;
      prevRas = rasN;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic waitFall();
    int c = fallCount;
    while (fallCount == c) step();
  endtask

  task automatic waitReqLow();
    while (busReq) step();
  endtask

  task automatic testPowerUp();
    chk(rasN && casN && weN && !busReq && !ready, "R1 reset state",
        {rasN, casN, weN, busReq, ready}, 5'b11100);
    step();
    rstN = 1'b1;
    waitFall();
    chk(lastFall - rstCyc >= INIT_WAIT, "R1 power-up pause", lastFall - rstCyc, INIT_WAIT);
    while (!ready) step();
    chk(fallCount == INIT_REF, "R1 power-up burst length", fallCount, INIT_REF);
  endtask

  task automatic testInterval();
    waitFall();
    for (int i = 0; i < 3; i++) begin
      waitFall();
      chk(lastFall - prevFall == INTERVAL, "R2 refresh interval", lastFall - prevFall, INTERVAL);
    end
  endtask

  task automatic testBacklog();
    int f, n0;
    waitFall();
    f = lastFall;
    waitReqLow();
    busGrant = 1'b0;
    while (cyc < f + 12 * INTERVAL + 10) begin
      if (busReq) chk(rasN && casN, "R3 strobes idle without grant", {rasN, casN}, 2'b11);
      step();
    end
    n0 = fallCount;
    busGrant = 1'b1;
    waitFall();
    while (busReq) begin
      step();
      if (fallCount != n0 + 1 && lastFall != prevFall && lastFall == cyc)
        chk(lastFall - prevFall == BURST_GAP, "R6 back-to-back spacing", lastFall - prevFall, BURST_GAP);
    end
    chk(fallCount - n0 == MAXOWED, "R6 capped backlog", fallCount - n0, MAXOWED);
  endtask

  task automatic testSelfAfterDebt();
    int f, n0;
    waitFall();
    f = lastFall;
    waitReqLow();
    busGrant = 1'b0;
    while (cyc < f + 2 * INTERVAL + 10) step();
    selfReq = 1'b1;
    step();
    chk(busReq && rasN && casN, "R3 request held, strobes idle", {busReq, rasN, casN}, 3'b111);
    n0 = fallCount;
    busGrant = 1'b1;
    for (int i = 0; i < 3; i++) begin
      waitFall();
      chk(!lastFallSelf, "R7 owed refreshes before self-refresh", int'(lastFallSelf), 0);
    end
    waitFall();
    chk(lastFallSelf && fallCount - n0 == 4, "R7 self entry after two owed and one extra",
        fallCount - n0, 4);
    chk(lastFall - prevFall == BURST_GAP, "R8 extra refresh just before entry",
        lastFall - prevFall, BURST_GAP);
    repeat (58) step();
    selfReq = 1'b0;
    repeat (3) step();
    chk(lastLowLen == 60, "R9 row low until request drops", lastLowLen, 60);
    chk(!inSelf, "R9 self flag cleared on exit", int'(inSelf), 0);
    n0 = fallCount;
    waitFall();
    chk(lastHigh == RPS + CSR, "R10 exit precharge", lastHigh, RPS + CSR);
    waitReqLow();
    chk(fallCount - n0 == 1, "R10 one refresh after exit", fallCount - n0, 1);
  endtask

  task automatic testShortSelf();
    selfReq = 1'b1;
    waitFall();
    waitFall();
    chk(lastFallSelf, "R9 self flag during entry", int'(lastFallSelf), 1);
    repeat (2) step();
    selfReq = 1'b0;
    while (!rasN) step();
    step();
    chk(lastLowLen == SELFMIN, "R9 minimum self-refresh low time", lastLowLen, SELFMIN);
    waitFall();
    chk(lastHigh == RPS + CSR, "R10 exit precharge after short stay", lastHigh, RPS + CSR);
    waitReqLow();
  endtask

  task automatic testLongSelf();
    int n0;
    selfReq = 1'b1;
    waitFall();
    waitFall();
    repeat (348) step();
    selfReq = 1'b0;
    while (!rasN) step();
    n0 = fallCount;
    waitReqLow();
    chk(fallCount - n0 == 1, "R11 no backlog from self-refresh", fallCount - n0, 1);
    n0 = fallCount;
    repeat (INTERVAL - 10) step();
    chk(fallCount == n0, "R11 quiet first interval after exit", fallCount - n0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (3) step();
    testPowerUp();
    testInterval();
    testBacklog();
    testSelfAfterDebt();
    testShortSelf();
    testLongSelf();
    finishRun();
  end

endmodule